// File: doc/BRIEF.md
# Compact Load-Store Processor Core

A single-issue processor core that executes one instruction per clock from a small internal instruction store. It has a 16-instruction set of word loads and stores, register arithmetic, bitwise logic, shifts, an unsigned compare, unconditional and compare-driven branches, and a halt. State is held in thirteen 16-bit general registers, a program counter and a word-addressed data store.

Software reaches the core only through the program write port. The port is used while reset is held, and the core starts fetching at address 0 once reset is released. A read port for one register and one data word exposes the architectural state. The `halted_o` output goes high once the core has stopped.

Top module: `lsc_core`

## Requirements
- R1: While `rst_ni` is low, the program counter, all general registers, the compare flags and `halted_o` are cleared to 0. The program and data stores keep their contents across reset.
- R2: Instructions are 32 bits wide, laid out as opcode [31:28], immediate flag [27], destination [26:23], first source [22:19], second source [18:15] and a 15-bit field [14:0]. The opcodes are 0 load, 1 store, 2 add, 3 subtract, 4 move, 5 compare, 6 branch, 7 branch-equal, 8 branch-not-equal, 9 branch-greater, 10 branch-less, 11 and, 12 or, 13 xor, 14 not, and 15 the extended group.
- R3: When the immediate flag is 1, the operand is the field [14:0] zero-extended. The extended group uses [12:0] instead. When the flag is 0, the operand is the value of the register named by [18:15].
- R4: Add and subtract write (Rn ± operand) mod 2^16 to Rd.
- R5: And, or and xor write Rn combined bitwise with the operand. Move writes the operand and not writes its inverse. Neither move nor not reads Rn.
- R6: In the extended group, field bits [14:13] select the action: 0 shifts left, 1 shifts right (logical, by the operand value), and 2 or 3 halts. A shift amount of 16 or more yields 0.
- R7: Load copies the data word at address field[5:0] into Rd. Store writes Rd to that address.
- R8: Compare latches three unsigned flags comparing Rn with the operand: equal, greater and less. Each conditional branch tests only the flags from the most recent compare.
- R9: A taken branch loads the program counter with field[5:0]. Every other non-halting instruction advances it by 1.
- R10: Once a halt executes, `halted_o` is 1 and `pc_o` holds the halt's address. From then until reset, no register or data word changes.
- R11: Register indices 13 to 15 read as 0, and writes to them are discarded.
- R12: A write on the program port stores `imem_wdata_i` at `imem_addr_i`. That word is executed when the program counter reaches the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_we_i | input | 1 | Program store write enable |
| imem_addr_i | input | 6 | Program store write address |
| imem_wdata_i | input | 32 | Program store write data |
| dbg_reg_sel_i | input | 4 | Register index to observe |
| dbg_reg_o | output | 16 | Value of the selected register |
| dbg_mem_addr_i | input | 6 | Data word address to observe |
| dbg_mem_o | output | 16 | Value of the selected data word |
| pc_o | output | 6 | Program counter |
| halted_o | output | 1 | Core has executed a halt |

## Verification
The program-counter properties assume the program store holds a defined word at every address the core can reach. The stimulus therefore loads each program completely while reset is held and ends every program with a halt, which keeps fetch inside loaded words. The properties also assume the program port is quiet while the core runs, and the bench writes only under reset.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [3:0] {
    OP_LDR, OP_STR, OP_ADD, OP_SUB, OP_MOV, OP_CMP, OP_B, OP_BEQ,
    OP_BNE, OP_BGT, OP_BLT, OP_AND, OP_ORR, OP_EOR, OP_MVN, OP_EXT
  } op_e;

  localparam logic [1:0] EXT_LSL = 2'd0;
  localparam logic [1:0] EXT_LSR = 2'd1;

  typedef struct packed {
    op_e         op;
    logic        imm;
    logic [3:0]  rd;
    logic [3:0]  rn;
    logic [3:0]  rm;
    logic [14:0] field;
  } instr_t;
endpackage

// File: rtl/lsc_regfile.sv
module lsc_regfile #(
  parameter int DATA_W = 16,
  parameter int NREG   = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [3:0]        wa_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic [3:0]        ra_a_i,
  input  logic [3:0]        ra_b_i,
  input  logic [3:0]        ra_c_i,
  input  logic [3:0]        ra_d_i,
  output logic [DATA_W-1:0] rd_a_o,
  output logic [DATA_W-1:0] rd_b_o,
  output logic [DATA_W-1:0] rd_c_o,
  output logic [DATA_W-1:0] rd_d_o
);
  localparam int SLOTS = 16;

  logic [DATA_W-1:0] rf [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < NREG) begin : g_real
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     rf[g] <= '0;
        else if (we_i && wa_i == 4'(g))  rf[g] <= wd_i;
      end
    end else begin : g_zero
      assign rf[g] = '0;
    end
  end

  assign rd_a_o = rf[ra_a_i];
  assign rd_b_o = rf[ra_b_i];
  assign rd_c_o = rf[ra_c_i];
  assign rd_d_o = rf[ra_d_i];
endmodule

// File: rtl/lsc_alu.sv
module lsc_alu
  import lsc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  op_e               op_i,
  input  logic [1:0]        ext_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      OP_ADD:  y_o = a_i + b_i;
      OP_SUB:  y_o = a_i - b_i;
      OP_MOV:  y_o = b_i;
      OP_AND:  y_o = a_i & b_i;
      OP_ORR:  y_o = a_i | b_i;
      OP_EOR:  y_o = a_i ^ b_i;
      OP_MVN:  y_o = ~b_i;
      OP_EXT:  y_o = (ext_i == EXT_LSL) ? (a_i << b_i) : (a_i >> b_i);
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/lsc_core.sv
module lsc_core
  import lsc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64,
  parameter int NREG       = 13
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          imem_we_i,
  input  logic [$clog2(IMEM_DEPTH)-1:0] imem_addr_i,
  input  logic [31:0]                   imem_wdata_i,
  input  logic [3:0]                    dbg_reg_sel_i,
  output logic [DATA_W-1:0]             dbg_reg_o,
  input  logic [$clog2(DMEM_DEPTH)-1:0] dbg_mem_addr_i,
  output logic [DATA_W-1:0]             dbg_mem_o,
  output logic [$clog2(IMEM_DEPTH)-1:0] pc_o,
  output logic                          halted_o
);
  localparam int IA_W = $clog2(IMEM_DEPTH);
  localparam int DA_W = $clog2(DMEM_DEPTH);

  logic [31:0]       imem [IMEM_DEPTH];
  logic [DATA_W-1:0] dmem [DMEM_DEPTH];

  logic [IA_W-1:0]   pc_q;
  logic              halted_q;
  logic              eq_q, gt_q, lt_q;

  instr_t            ins;
  logic [DATA_W-1:0] rn_val, rm_val, rd_val, opnd, alu_y, wr_data;
  logic [1:0]        ext_sel;
  logic              is_hlt, br_take, rf_we;
  logic [IA_W-1:0]   br_target;
  logic [DA_W-1:0]   mem_addr;

  always_ff @(posedge clk_i) begin
    if (imem_we_i) imem[imem_addr_i] <= imem_wdata_i;
  end

  assign ins       = instr_t'(imem[pc_q]);
  assign ext_sel   = ins.field[14:13];
  assign is_hlt    = (ins.op == OP_EXT) && ext_sel[1];
  assign br_target = ins.field[IA_W-1:0];
  assign mem_addr  = ins.field[DA_W-1:0];

  lsc_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (rf_we),
    .wa_i   (ins.rd),
    .wd_i   (wr_data),
    .ra_a_i (ins.rn),
    .ra_b_i (ins.rm),
    .ra_c_i (ins.rd),
    .ra_d_i (dbg_reg_sel_i),
    .rd_a_o (rn_val),
    .rd_b_o (rm_val),
    .rd_c_o (rd_val),
    .rd_d_o (dbg_reg_o)
  );

  always_comb begin
    if (!ins.imm)              opnd = rm_val;
    else if (ins.op == OP_EXT) opnd = DATA_W'(ins.field[12:0]);
    else                       opnd = DATA_W'(ins.field);
  end

  lsc_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (ins.op),
    .ext_i (ext_sel),
    .a_i   (rn_val),
    .b_i   (opnd),
    .y_o   (alu_y)
  );

  assign wr_data = (ins.op == OP_LDR) ? dmem[mem_addr] : alu_y;

  always_comb begin
    unique case (ins.op)
      OP_LDR, OP_ADD, OP_SUB, OP_MOV,
      OP_AND, OP_ORR, OP_EOR, OP_MVN: rf_we = !halted_q;
      OP_EXT:                         rf_we = !halted_q && !ext_sel[1];
      default:                        rf_we = 1'b0;
    endcase
  end

  always_comb begin
    unique case (ins.op)
      OP_B:    br_take = 1'b1;
      OP_BEQ:  br_take = eq_q;
      OP_BNE:  br_take = !eq_q;
      OP_BGT:  br_take = gt_q;
      OP_BLT:  br_take = lt_q;
      default: br_take = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!halted_q && ins.op == OP_STR) dmem[mem_addr] <= rd_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      halted_q <= 1'b0;
      eq_q     <= 1'b0;
      gt_q     <= 1'b0;
      lt_q     <= 1'b0;
    end else if (!halted_q) begin
      if (is_hlt)       halted_q <= 1'b1;
      else if (br_take) pc_q     <= br_target;
      else              pc_q     <= pc_q + 1'b1;
      if (ins.op == OP_CMP) begin
        eq_q <= (rn_val == opnd);
        gt_q <= (rn_val >  opnd);
        lt_q <= (rn_val <  opnd);
      end
    end
  end

  assign dbg_mem_o = dmem[dbg_mem_addr_i];
  assign pc_o      = pc_q;
  assign halted_o  = halted_q;
endmodule

// File: rtl/lsc_core_chk.sv
module lsc_core_chk #(
  parameter int IA_W   = 6,
  parameter int DATA_W = 16,
  parameter int NREG   = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IA_W-1:0]   pc_o,
  input logic              halted_o,
  input logic              br_take,
  input logic              hlt_exec,
  input logic [IA_W-1:0]   br_target,
  input logic [3:0]        dbg_reg_sel_i,
  input logic [DATA_W-1:0] dbg_reg_o
);
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o); // R10
  AST_HALT_PC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> $stable(pc_o)); // R10
  AST_HLT_ENTERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && hlt_exec) |=> (halted_o && $stable(pc_o))); // R10
  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && !hlt_exec && !br_take) |=> pc_o == IA_W'($past(pc_o) + 1'b1)); // R9
  AST_BRANCH_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && !hlt_exec && br_take) |=> pc_o == $past(br_target)); // R9
  AST_HIGH_REG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(dbg_reg_sel_i) >= NREG) |-> dbg_reg_o == '0); // R11
endmodule

bind lsc_core lsc_core_chk #(
  .IA_W   ($clog2(IMEM_DEPTH)),
  .DATA_W (DATA_W),
  .NREG   (NREG)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pc_o          (pc_o),
  .halted_o      (halted_o),
  .br_take       (br_take),
  .hlt_exec      (is_hlt),
  .br_target     (br_target),
  .dbg_reg_sel_i (dbg_reg_sel_i),
  .dbg_reg_o     (dbg_reg_o)
);

// File: tb/lsc_core_tb.sv
module lsc_core_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        imem_we_i = 1'b0;
  logic [5:0]  imem_addr_i = '0;
  logic [31:0] imem_wdata_i = '0;
  logic [3:0]  dbg_reg_sel_i = '0;
  logic [15:0] dbg_reg_o;
  logic [5:0]  dbg_mem_addr_i = '0;
  logic [15:0] dbg_mem_o;
  logic [5:0]  pc_o;
  logic        halted_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  lsc_core dut_i (
    .clk_i, .rst_ni, .imem_we_i, .imem_addr_i, .imem_wdata_i,
    .dbg_reg_sel_i, .dbg_reg_o, .dbg_mem_addr_i, .dbg_mem_o, .pc_o, .halted_o
  );

  function automatic logic [31:0] enc(input logic [3:0] op, input logic im,
      input logic [3:0] rd, input logic [3:0] rn, input logic [3:0] rm,
      input logic [14:0] fld);
    return {op, im, rd, rn, rm, fld};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input int idx, input logic [31:0] w);
    @(negedge clk_i);
    imem_we_i = 1'b1; imem_addr_i = 6'(idx); imem_wdata_i = w;
    @(negedge clk_i);
    imem_we_i = 1'b0;
  endtask

  task automatic reg_is(input string tag, input int r, input logic [15:0] exp);
    dbg_reg_sel_i = 4'(r);
    #1;
    chk(tag, 32'(dbg_reg_o), 32'(exp));
  endtask

  task automatic run(input int cycles);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (cycles) @(negedge clk_i);
  endtask

  task automatic hold_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
  endtask

  // ALU, operands, memory, shifts and high-register handling
  task automatic t_datapath();
    hold_reset();
    put(0,  enc(4, 1, 1, 0, 0, 15'd5));            // MOV R1,#5
    put(1,  enc(4, 1, 2, 0, 0, 15'd3));            // MOV R2,#3
    put(2,  enc(2, 0, 3, 1, 2, 15'd0));            // ADD R3,R1,R2
    put(3,  enc(3, 1, 4, 2, 0, 15'd5));            // SUB R4,R2,#5
    put(4,  enc(11, 1, 5, 1, 0, 15'd6));           // AND R5,R1,#6
    put(5,  enc(12, 0, 6, 1, 2, 15'd0));           // ORR R6,R1,R2
    put(6,  enc(13, 1, 7, 1, 0, 15'd15));          // EOR R7,R1,#15
    put(7,  enc(14, 0, 8, 2, 1, 15'd0));           // MVN R8,R1 (Rn=R2 unused)
    put(8,  enc(15, 1, 9, 1, 0, {2'd0, 13'd4}));   // LSL R9,R1,#4
    put(9,  enc(15, 1, 10, 8, 0, {2'd1, 13'd12})); // LSR R10,R8,#12
    put(10, enc(1, 1, 3, 0, 0, 15'd20));           // STR R3,[20]
    put(11, enc(0, 1, 11, 0, 0, 15'd20));          // LDR R11,[20]
    put(12, enc(4, 1, 12, 0, 0, 15'd9));           // MOV R12,#9
    put(13, enc(15, 1, 12, 12, 0, {2'd0, 13'd20}));// LSL R12,R12,#20
    put(14, enc(4, 1, 13, 0, 0, 15'd7));           // MOV R13,#7
    put(15, enc(2, 0, 0, 1, 13, 15'd0));           // ADD R0,R1,R13
    put(16, enc(4, 1, 2, 1, 0, 15'h1234));         // MOV R2,#0x1234 (Rn=R1 unused)
    put(17, enc(15, 1, 0, 0, 0, {2'd2, 13'd0}));   // HLT
    run(60);
    reg_is("R12 program words executed", 1, 16'd5);
    reg_is("R4 add", 3, 16'd8);
    reg_is("R4 sub wraps", 4, 16'hFFFE);
    reg_is("R5 and imm", 5, 16'd4);
    reg_is("R5 orr reg", 6, 16'd7);
    reg_is("R3 eor imm", 7, 16'd10);
    reg_is("R5 mvn ignores rn", 8, 16'hFFFA);
    reg_is("R6 lsl", 9, 16'h0050);
    reg_is("R6 lsr", 10, 16'h000F);
    reg_is("R6 shift>=16 is zero", 12, 16'd0);
    reg_is("R7 ldr after str", 11, 16'd8);
    dbg_mem_addr_i = 6'd20; #1;
    chk("R7 str data word", 32'(dbg_mem_o), 32'd8);
    reg_is("R11 r13 reads zero", 13, 16'd0);
    reg_is("R11 r13 as operand", 0, 16'd5);
    reg_is("R5 mov ignores rn", 2, 16'h1234);
    chk("R10 halted", 32'(halted_o), 32'd1);
    chk("R10 pc at halt", 32'(pc_o), 32'd17);
  endtask

  // compare and branch behaviour
  task automatic t_branches();
    hold_reset();
    put(0,  enc(4, 1, 1, 0, 0, 15'd0));            // MOV R1,#0
    put(1,  enc(2, 1, 1, 1, 0, 15'd1));            // ADD R1,R1,#1
    put(2,  enc(5, 1, 0, 1, 0, 15'd4));            // CMP R1,#4
    put(3,  enc(10, 0, 0, 0, 0, 15'd1));           // BLT 1
    put(4,  enc(5, 1, 0, 1, 0, 15'd4));            // CMP R1,#4
    put(5,  enc(7, 0, 0, 0, 0, 15'd7));            // BEQ 7
    put(6,  enc(4, 1, 2, 0, 0, 15'd99));           // MOV R2,#99 (skipped)
    put(7,  enc(8, 0, 0, 0, 0, 15'd9));            // BNE 9 (not taken)
    put(8,  enc(4, 1, 3, 0, 0, 15'd1));            // MOV R3,#1
    put(9,  enc(5, 1, 0, 1, 0, 15'd2));            // CMP R1,#2
    put(10, enc(9, 0, 0, 0, 0, 15'd12));           // BGT 12
    put(11, enc(4, 1, 4, 0, 0, 15'd1));            // MOV R4,#1 (skipped)
    put(12, enc(6, 0, 0, 0, 0, 15'd14));           // B 14
    put(13, enc(4, 1, 5, 0, 0, 15'd1));            // MOV R5,#1 (skipped)
    put(14, enc(15, 1, 0, 0, 0, {2'd2, 13'd0}));   // HLT
    run(60);
    reg_is("R8 blt loop count", 1, 16'd4);
    reg_is("R8 beq taken skip", 2, 16'd0);
    reg_is("R8 bne falls through", 3, 16'd1);
    reg_is("R8 bgt taken skip", 4, 16'd0);
    reg_is("R9 b unconditional", 5, 16'd0);
    chk("R9 pc at halt", 32'(pc_o), 32'd14);
  endtask

  // reset, wrap-around and halt freeze
  task automatic t_reset_halt();
    hold_reset();
    #1;
    chk("R1 halted clear", 32'(halted_o), 32'd0);
    chk("R1 pc clear", 32'(pc_o), 32'd0);
    reg_is("R1 reg clear", 1, 16'd0);
    put(0, enc(4, 1, 1, 0, 0, 15'h7FFF));          // MOV R1,#0x7FFF
    put(1, enc(2, 0, 1, 1, 1, 15'd0));             // ADD R1,R1,R1
    put(2, enc(2, 1, 1, 1, 0, 15'd3));             // ADD R1,R1,#3
    put(3, enc(3, 1, 2, 0, 0, 15'd1));             // SUB R2,R0,#1
    put(4, enc(15, 1, 0, 0, 0, {2'd3, 13'd0}));    // HLT (code 3)
    put(5, enc(4, 1, 1, 0, 0, 15'd2));             // MOV R1,#2
    put(6, enc(1, 1, 1, 0, 0, 15'd20));            // STR R1,[20]
    run(20);
    reg_is("R4 add wraps", 1, 16'd1);
    reg_is("R4 sub below zero", 2, 16'hFFFF);
    chk("R10 halt code 3", 32'(halted_o), 32'd1);
    chk("R10 pc held", 32'(pc_o), 32'd4);
    repeat (30) @(negedge clk_i);
    chk("R10 pc still held", 32'(pc_o), 32'd4);
    reg_is("R10 reg frozen", 1, 16'd1);
    dbg_mem_addr_i = 6'd20; #1;
    chk("R10 mem frozen", 32'(dbg_mem_o), 32'd8);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_datapath();
    t_branches();
    t_reset_halt();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule